// File: doc/BRIEF.md
# Flash prefetch line buffer controller

This block sits between a simple single-request bus read port and the read interface of a flash array. It keeps a small set of 128-bit line buffers. A bus read that finds its line in a valid buffer is answered in the same cycle. A read that misses starts one array read. The block then counts a programmable number of wait states, takes the line from the array, and answers the bus in that same cycle. After a read has been delivered, the block may fetch the next sequential line ahead of demand. Whether it does depends on the access type (instruction or data), on a per-master enable, and on which buffers are enabled to take fills of that type.

Every request is first checked against a per-master read/write permission field. A request that breaks its permission gets an error response in its own cycle. A permitted write is acknowledged at once and leaves the buffers unchanged. A master holds its request (valid, address, attributes) stable until the cycle in which `rsp_valid_o` is high; that cycle completes the transfer.

Top module: `flash_linebuf_ctrl`

## Requirements
- R1: A permitted read whose line sits in a valid buffer gets `rsp_valid_o` high with correct data in the cycle the request is first presented (zero wait states), and at most one buffer ever matches a line.
- R2: Read data is 32 bits; byte address bits [3:2] select word k of the 128-bit line, and word k occupies line bits [32k+31:32k].
- R3: A permitted read that misses drives `arr_rd_o` with the line address held stable. With `cfg_wait_i` = W, the response comes W+1 cycles after the request cycle, carrying the selected word of `arr_rdata_i`.
- R4: Only one array read is in flight at a time, and a demand miss is launched ahead of a pending prefetch that has not yet started.
- R5: After a delivered read, line+1 is prefetched when the trigger mode allows it. The encoding of `cfg_trig_i` is 0 = never, 1 = instruction reads only, 2 = data reads only, 3 = any read.
- R6: Bit m of `cfg_mst_pf_i` enables prefetch triggering by reads from master m; with the bit clear, reads from that master trigger nothing.
- R7: Bit b of `cfg_ialloc_i` / `cfg_dalloc_i` allows buffer b to take instruction / data fills. A fill with no enabled buffer is delivered but not retained.
- R8: A fill replaces the lowest-numbered invalid enabled buffer; if there is none, it replaces the least recently used enabled buffer. A use is a hit or a fill.
- R9: A change of `cfg_trig_i`, `cfg_mst_pf_i`, `cfg_ialloc_i` or `cfg_dalloc_i` invalidates every buffer and cancels a pending prefetch.
- R10: `cfg_perm_i[2m+1:2m]` holds the permission of master m: bit 2m allows reads and bit 2m+1 allows writes. A request without permission is answered with `rsp_valid_o` and `rsp_err_o` high in its own cycle.
- R11: A permitted write is answered without error in its own cycle and leaves buffer contents unchanged.
- R12: During and just after reset no buffer is valid, no array read is active and no response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present, held until response |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_instr_i | input | 1 | 1 = instruction access, 0 = data access |
| req_master_i | input | 2 | Requesting master |
| req_addr_i | input | 20 | Byte address |
| rsp_valid_o | output | 1 | Response this cycle |
| rsp_err_o | output | 1 | Error response (permission violation) |
| rsp_rdata_o | output | 32 | Read data |
| cfg_wait_i | input | 4 | Array read wait states |
| cfg_trig_i | input | 2 | Prefetch trigger mode |
| cfg_mst_pf_i | input | 4 | Per-master prefetch trigger enable |
| cfg_ialloc_i | input | 4 | Per-buffer instruction fill enable |
| cfg_dalloc_i | input | 4 | Per-buffer data fill enable |
| cfg_perm_i | input | 8 | Per-master read/write permission |
| arr_rd_o | output | 1 | Array read in progress |
| arr_line_o | output | 16 | Line address of the array read |
| arr_rdata_i | input | 128 | Array line data |

## Verification
The bench builds the block with its default parameters: four buffers, four masters, a 20-bit address and 128-bit lines. With four buffers, a short sequence of five distinct lines fills every buffer and then forces an LRU eviction. It also makes a single enabled buffer a meaningful allocation corner. The wait-state setting is swept from 0 to 3 across all four word offsets, and every combination of trigger mode, access type and master enable is visited. All four permission codes of every master are swept for both reads and writes. The array model returns a word computed from the line address and word index, so every expected value is arithmetic.

// File: rtl/flpf_pkg.sv
package flpf_pkg;

  typedef enum logic [1:0] {
    TRIG_OFF   = 2'd0,
    TRIG_INSTR = 2'd1,
    TRIG_DATA  = 2'd2,
    TRIG_ANY   = 2'd3
  } trig_mode_e;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;

  function automatic logic trig_allows(input logic [1:0] mode, input logic is_instr);
    case (trig_mode_e'(mode))
      TRIG_INSTR: return is_instr;
      TRIG_DATA:  return !is_instr;
      TRIG_ANY:   return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/flpf_prot.sv
module flpf_prot #(
  parameter int unsigned NUM_MST = 4,
  parameter int unsigned MST_W   = 2
) (
  input  logic [MST_W-1:0]     master_i,
  input  logic                 write_i,
  input  logic [2*NUM_MST-1:0] perm_i,
  output logic                 allow_o
);

  always_comb begin
    allow_o = 1'b0;
    for (int m = 0; m < int'(NUM_MST); m++) begin
      if (master_i == MST_W'(m)) allow_o = write_i ? perm_i[2*m+1] : perm_i[2*m];
    end
  end

endmodule

// File: rtl/flpf_lru.sv
module flpf_lru #(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned IDX_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               touch_i,
  input  logic [IDX_W-1:0]   touch_idx_i,
  input  logic [NUM_BUF-1:0] cand_i,
  input  logic [NUM_BUF-1:0] valid_i,
  output logic [IDX_W-1:0]   victim_o,
  output logic               victim_ok_o
);

  // age 0 = most recent; ages always form a permutation of 0..NUM_BUF-1
  logic [IDX_W-1:0] age_q [NUM_BUF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < int'(NUM_BUF); b++) age_q[b] <= IDX_W'(b);
    end else if (touch_i) begin
      for (int b = 0; b < int'(NUM_BUF); b++) begin
        if (IDX_W'(b) == touch_idx_i)             age_q[b] <= '0;
        else if (age_q[b] < age_q[touch_idx_i])   age_q[b] <= age_q[b] + 1'b1;
      end
    end
  end

  logic             found_inv;
  logic [IDX_W-1:0] best_age;

  always_comb begin
    found_inv   = 1'b0;
    victim_o    = '0;
    victim_ok_o = 1'b0;
    best_age    = '0;
    for (int b = 0; b < int'(NUM_BUF); b++) begin
      if (cand_i[b] && !valid_i[b] && !found_inv) begin
        victim_o    = IDX_W'(b);
        victim_ok_o = 1'b1;
        found_inv   = 1'b1;
      end
    end
    if (!found_inv) begin
      for (int b = 0; b < int'(NUM_BUF); b++) begin
        if (cand_i[b] && (!victim_ok_o || age_q[b] > best_age)) begin
          victim_o    = IDX_W'(b);
          best_age    = age_q[b];
          victim_ok_o = 1'b1;
        end
      end
    end
  end

  logic [NUM_BUF-1:0] age_seen;
  always_comb begin
    age_seen = '0;
    for (int b = 0; b < int'(NUM_BUF); b++) age_seen[age_q[b]] = 1'b1;
  end

  p_age_perm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(age_seen) == NUM_BUF);

endmodule

// File: rtl/flpf_line_store.sv
module flpf_line_store #(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned LINE_AW = 16,
  parameter int unsigned LINE_W  = 128,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned WSEL_W  = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [LINE_AW-1:0] look_line_i,
  input  logic [WSEL_W-1:0]  word_sel_i,
  input  logic [LINE_AW-1:0] probe_line_i,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [LINE_AW-1:0] wr_line_i,
  input  logic [LINE_W-1:0]  wr_data_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   hit_idx_o,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               probe_hit_o,
  output logic [NUM_BUF-1:0] valid_o
);

  logic [NUM_BUF-1:0]             hit_vec;
  logic [NUM_BUF-1:0]             probe_vec;
  logic [NUM_BUF-1:0][WORD_W-1:0] word_arr;

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic               valid_q;
    logic [LINE_AW-1:0] tag_q;
    logic [LINE_W-1:0]  data_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q <= 1'b0;
        tag_q   <= '0;
        data_q  <= '0;
      end else if (flush_i) begin
        valid_q <= 1'b0;
      end else if (wr_en_i && wr_idx_i == IDX_W'(b)) begin
        valid_q <= 1'b1;
        tag_q   <= wr_line_i;
        data_q  <= wr_data_i;
      end
    end

    assign valid_o[b]   = valid_q;
    assign hit_vec[b]   = valid_q && (tag_q == look_line_i);
    assign probe_vec[b] = valid_q && (tag_q == probe_line_i);
    assign word_arr[b]  = data_q[word_sel_i*WORD_W +: WORD_W];
  end

  always_comb begin
    hit_idx_o = '0;
    rdata_o   = '0;
    for (int b = 0; b < int'(NUM_BUF); b++) begin
      if (hit_vec[b]) begin
        hit_idx_o = IDX_W'(b);
        rdata_o   = word_arr[b];
      end
    end
  end

  assign hit_o       = |hit_vec;
  assign probe_hit_o = |probe_vec;

  p_single_match_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));

  p_flush_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_o == '0));

endmodule

// File: rtl/flash_linebuf_ctrl.sv
module flash_linebuf_ctrl
  import flpf_pkg::*;
#(
  parameter int unsigned NUM_BUF = 4,
  parameter int unsigned NUM_MST = 4,
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned LINE_W  = 128,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned WAIT_W  = 4,
  localparam int unsigned IDX_W   = $clog2(NUM_BUF),
  localparam int unsigned MST_W   = (NUM_MST > 1) ? $clog2(NUM_MST) : 1,
  localparam int unsigned OFF_W   = $clog2(LINE_W / 8),
  localparam int unsigned BYTE_W  = $clog2(WORD_W / 8),
  localparam int unsigned WSEL_W  = $clog2(LINE_W / WORD_W),
  localparam int unsigned LINE_AW = ADDR_W - OFF_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic                 req_write_i,
  input  logic                 req_instr_i,
  input  logic [MST_W-1:0]     req_master_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  output logic                 rsp_valid_o,
  output logic                 rsp_err_o,
  output logic [WORD_W-1:0]    rsp_rdata_o,
  input  logic [WAIT_W-1:0]    cfg_wait_i,
  input  logic [1:0]           cfg_trig_i,
  input  logic [NUM_MST-1:0]   cfg_mst_pf_i,
  input  logic [NUM_BUF-1:0]   cfg_ialloc_i,
  input  logic [NUM_BUF-1:0]   cfg_dalloc_i,
  input  logic [2*NUM_MST-1:0] cfg_perm_i,
  output logic                 arr_rd_o,
  output logic [LINE_AW-1:0]   arr_line_o,
  input  logic [LINE_W-1:0]    arr_rdata_i
);

  localparam int unsigned CFG_W = 2 + NUM_MST + 2 * NUM_BUF;

  // request decode
  logic [LINE_AW-1:0] req_line;
  logic [WSEL_W-1:0]  req_word;
  logic               unused_byte_bits;
  assign req_line         = req_addr_i[ADDR_W-1:OFF_W];
  assign req_word         = req_addr_i[BYTE_W +: WSEL_W];
  assign unused_byte_bits = ^req_addr_i[BYTE_W-1:0];

  logic perm_ok;
  flpf_prot #(.NUM_MST(NUM_MST), .MST_W(MST_W)) u_prot (
    .master_i (req_master_i),
    .write_i  (req_write_i),
    .perm_i   (cfg_perm_i),
    .allow_o  (perm_ok)
  );

  // fill engine state
  fill_state_e        st_q;
  logic [WAIT_W-1:0]  cnt_q;
  logic [LINE_AW-1:0] fill_line_q;
  logic               fill_instr_q;
  logic               fill_drop_q;
  logic               pf_pend_q;
  logic [LINE_AW-1:0] pf_line_q;
  logic               pf_instr_q;
  logic [CFG_W-1:0]   snap_q;

  logic [CFG_W-1:0] cfg_now;
  logic             cfg_chg;
  assign cfg_now = {cfg_trig_i, cfg_mst_pf_i, cfg_ialloc_i, cfg_dalloc_i};
  assign cfg_chg = (cfg_now != snap_q);

  // buffers and replacement
  logic               st_hit;
  logic [IDX_W-1:0]   st_hit_idx;
  logic [WORD_W-1:0]  st_rdata;
  logic               probe_hit;
  logic [NUM_BUF-1:0] buf_valid;
  logic [NUM_BUF-1:0] alloc_vec;
  logic [IDX_W-1:0]   victim;
  logic               victim_ok;
  logic               fill_done;
  logic               fill_wr;
  logic               touch;
  logic [IDX_W-1:0]   touch_idx;

  assign fill_done = (st_q == FILL_BUSY) && (cnt_q == '0);
  assign alloc_vec = fill_instr_q ? cfg_ialloc_i : cfg_dalloc_i;
  assign fill_wr   = fill_done && !fill_drop_q && victim_ok;

  flpf_line_store #(
    .NUM_BUF (NUM_BUF),
    .IDX_W   (IDX_W),
    .LINE_AW (LINE_AW),
    .LINE_W  (LINE_W),
    .WORD_W  (WORD_W),
    .WSEL_W  (WSEL_W)
  ) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (cfg_chg),
    .look_line_i  (req_line),
    .word_sel_i   (req_word),
    .probe_line_i (pf_line_q),
    .wr_en_i      (fill_wr),
    .wr_idx_i     (victim),
    .wr_line_i    (fill_line_q),
    .wr_data_i    (arr_rdata_i),
    .hit_o        (st_hit),
    .hit_idx_o    (st_hit_idx),
    .rdata_o      (st_rdata),
    .probe_hit_o  (probe_hit),
    .valid_o      (buf_valid)
  );

  flpf_lru #(.NUM_BUF(NUM_BUF), .IDX_W(IDX_W)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_i     (touch),
    .touch_idx_i (touch_idx),
    .cand_i      (alloc_vec),
    .valid_i     (buf_valid),
    .victim_o    (victim),
    .victim_ok_o (victim_ok)
  );

  // response path
  logic rd_req;
  logic rd_ok;
  logic fill_hit;
  logic demand_miss;
  logic launch_dem;
  logic launch_pf;
  logic pf_skip;
  logic pf_alloc_any;
  logic pf_trig;

  assign rd_req      = req_valid_i && !req_write_i;
  assign rd_ok       = rd_req && perm_ok;
  assign fill_hit    = fill_done && (fill_line_q == req_line);
  assign demand_miss = rd_ok && !st_hit && !fill_hit;

  always_comb begin
    rsp_valid_o = 1'b0;
    rsp_err_o   = 1'b0;
    rsp_rdata_o = '0;
    if (req_valid_i && !perm_ok) begin
      rsp_valid_o = 1'b1;
      rsp_err_o   = 1'b1;
    end else if (req_valid_i && req_write_i) begin
      rsp_valid_o = 1'b1;
    end else if (rd_ok && st_hit) begin
      rsp_valid_o = 1'b1;
      rsp_rdata_o = st_rdata;
    end else if (rd_ok && fill_hit) begin
      rsp_valid_o = 1'b1;
      rsp_rdata_o = arr_rdata_i[req_word*WORD_W +: WORD_W];
    end
  end

  // fill write wins the LRU port over a concurrent hit
  assign touch     = fill_wr || (rd_ok && st_hit);
  assign touch_idx = fill_wr ? victim : st_hit_idx;

  // prefetch control
  assign pf_alloc_any = |(pf_instr_q ? cfg_ialloc_i : cfg_dalloc_i);
  assign pf_trig      = rsp_valid_o && !rsp_err_o && !req_write_i
                        && trig_allows(cfg_trig_i, req_instr_i)
                        && cfg_mst_pf_i[req_master_i];
  assign launch_dem   = demand_miss && (st_q == FILL_IDLE);
  assign pf_skip      = pf_pend_q && (st_q == FILL_IDLE) && !demand_miss
                        && (probe_hit || !pf_alloc_any);
  assign launch_pf    = pf_pend_q && (st_q == FILL_IDLE) && !demand_miss
                        && !probe_hit && pf_alloc_any && !cfg_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= FILL_IDLE;
      cnt_q        <= '0;
      fill_line_q  <= '0;
      fill_instr_q <= 1'b0;
      fill_drop_q  <= 1'b0;
      pf_pend_q    <= 1'b0;
      pf_line_q    <= '0;
      pf_instr_q   <= 1'b0;
      snap_q       <= '0;
    end else begin
      snap_q <= cfg_now;
      if (st_q == FILL_IDLE) begin
        if (launch_dem) begin
          st_q         <= FILL_BUSY;
          cnt_q        <= cfg_wait_i;
          fill_line_q  <= req_line;
          fill_instr_q <= req_instr_i;
          fill_drop_q  <= cfg_chg;
        end else if (launch_pf) begin
          st_q         <= FILL_BUSY;
          cnt_q        <= cfg_wait_i;
          fill_line_q  <= pf_line_q;
          fill_instr_q <= pf_instr_q;
          fill_drop_q  <= 1'b0;
        end
      end else begin
        if (cnt_q == '0) st_q <= FILL_IDLE;
        else             cnt_q <= cnt_q - 1'b1;
        if (cfg_chg) fill_drop_q <= 1'b1;
      end
      if (cfg_chg) begin
        pf_pend_q <= 1'b0;
      end else if (pf_trig) begin
        pf_pend_q  <= 1'b1;
        pf_line_q  <= req_line + 1'b1;
        pf_instr_q <= req_instr_i;
      end else if (launch_pf || pf_skip) begin
        pf_pend_q <= 1'b0;
      end
    end
  end

  assign arr_rd_o   = (st_q == FILL_BUSY);
  assign arr_line_o = fill_line_q;

  p_line_held_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_rd_o && cnt_q != '0) |=> (arr_rd_o && $stable(arr_line_o)));

  p_wait_loaded_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(arr_rd_o) |-> (cnt_q == $past(cfg_wait_i)));

  p_demand_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_pend_q && !arr_rd_o && demand_miss) |=> (arr_rd_o && arr_line_o == $past(req_line)));

  p_hit_now_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_ok && st_hit) |-> (rsp_valid_o && !rsp_err_o));

  p_fill_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_wr |-> alloc_vec[victim]);

  p_read_denied_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && !cfg_perm_i[{req_master_i, 1'b0}]) |-> (rsp_valid_o && rsp_err_o));

  p_write_ok_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && cfg_perm_i[{req_master_i, 1'b1}]) |-> (rsp_valid_o && !rsp_err_o));

endmodule

// File: tb/flash_linebuf_ctrl_test.sv
`timescale 1ns/1ps
module flash_linebuf_ctrl_test;

  localparam logic [31:0] SALT = 32'hA5A5_0000;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic         req_instr = 1'b0;
  logic [1:0]   req_master = '0;
  logic [19:0]  req_addr = '0;
  logic         rsp_valid_o;
  logic         rsp_err_o;
  logic [31:0]  rsp_rdata_o;
  logic [3:0]   cfg_wait = '0;
  logic [1:0]   cfg_trig = '0;
  logic [3:0]   cfg_mst_pf = '0;
  logic [3:0]   cfg_ialloc = 4'hf;
  logic [3:0]   cfg_dalloc = 4'hf;
  logic [7:0]   cfg_perm = 8'hff;
  logic         arr_rd_o;
  logic [15:0]  arr_line_o;
  logic [127:0] arr_rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  always_comb begin
    for (int k = 0; k < 4; k++) arr_rdata[32*k +: 32] = {14'd0, arr_line_o, 2'(k)} ^ SALT;
  end

  flash_linebuf_ctrl uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid),
    .req_write_i  (req_write),
    .req_instr_i  (req_instr),
    .req_master_i (req_master),
    .req_addr_i   (req_addr),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_err_o    (rsp_err_o),
    .rsp_rdata_o  (rsp_rdata_o),
    .cfg_wait_i   (cfg_wait),
    .cfg_trig_i   (cfg_trig),
    .cfg_mst_pf_i (cfg_mst_pf),
    .cfg_ialloc_i (cfg_ialloc),
    .cfg_dalloc_i (cfg_dalloc),
    .cfg_perm_i   (cfg_perm),
    .arr_rd_o     (arr_rd_o),
    .arr_line_o   (arr_line_o),
    .arr_rdata_i  (arr_rdata)
  );

  function automatic logic [31:0] exp_word(input logic [19:0] a);
    return {14'd0, a[19:2]} ^ SALT;
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the response
  task automatic access(input bit wr, input logic [1:0] m, input bit ins, input logic [19:0] a,
                        output int lat, output logic [31:0] d, output bit e);
    req_valid  = 1'b1;
    req_write  = wr;
    req_instr  = ins;
    req_master = m;
    req_addr   = a;
    lat = 0;
    d = '0;
    e = 1'b0;
    forever begin
      #1;
      if (rsp_valid_o) begin
        d = rsp_rdata_o;
        e = rsp_err_o;
        break;
      end
      if (lat > 200) begin
        lat = -1;
        break;
      end
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  int          lat;
  logic [31:0] d;
  bit          e;

  // read with latency and data checks
  task automatic rd_chk(input string tag, input logic [1:0] m, input bit ins,
                        input logic [19:0] a, input int exp_lat);
    access(1'b0, m, ins, a, lat, d, e);
    chk(tag, "latency", lat, exp_lat);
    chk(tag, "data", d, exp_word(a));
  endtask

  task automatic set_cfg(input logic [3:0] w, input logic [1:0] t, input logic [3:0] pf,
                         input logic [3:0] ia, input logic [3:0] da);
    cfg_wait = w; cfg_trig = t; cfg_mst_pf = pf; cfg_ialloc = ia; cfg_dalloc = da;
    idle(3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "rsp_valid in reset", rsp_valid_o, 0);
    chk("R12", "arr_rd in reset", arr_rd_o, 0);
    rst_ni = 1'b1;
    idle(3);
    chk("R12", "arr_rd after reset", arr_rd_o, 0);
    chk("R12", "rsp_valid after reset", rsp_valid_o, 0);

    // R3 / R2 / R1: wait-state sweep over all word offsets
    for (int w = 0; w < 4; w++) begin
      cfg_wait = 4'(w);
      for (int k = 0; k < 4; k++) begin
        logic [19:0] a;
        a = {16'(16 + w*8 + k), 2'(k), 2'b00};
        rd_chk("R3", 2'd0, 1'b0, a, w + 1);
        rd_chk("R1", 2'd0, 1'b0, a, 0);
        a[3:2] = 2'(k + 1);
        rd_chk("R2", 2'd0, 1'b0, a, 0);
        idle(1);
      end
    end

    // R5 / R6: trigger mode x access type x master enable
    for (int mode = 0; mode < 4; mode++) begin
      for (int ins = 0; ins < 2; ins++) begin
        for (int en = 0; en < 2; en++) begin
          logic [1:0]  m;
          logic [3:0]  pf;
          logic [15:0] ln;
          bit          allow;
          m  = 2'(mode + ins);
          pf = en ? (4'b0001 << m) : (~(4'b0001 << m));
          ln = 16'h0100 + 16'(mode*16 + ins*8 + en*4);
          allow = (en == 1) && (mode == 3 || (mode == 1 && ins == 1) || (mode == 2 && ins == 0));
          set_cfg(4'd1, 2'(mode), pf, 4'hf, 4'hf);
          rd_chk(en ? "R5" : "R6", m, ins[0], {ln, 4'h0}, 2);
          idle(6);
          rd_chk(en ? "R5" : "R6", m, ins[0], {ln + 16'd1, 4'h4}, allow ? 0 : 2);
          idle(6);
        end
      end
    end

    // R4: demand miss goes ahead of the pending prefetch
    set_cfg(4'd3, 2'd3, 4'hf, 4'hf, 4'hf);
    rd_chk("R4", 2'd1, 1'b1, 20'h02000, 4);
    rd_chk("R4", 2'd1, 1'b1, 20'h03008, 4);
    idle(12);

    // R8: LRU replacement, prefetch off
    set_cfg(4'd0, 2'd0, 4'h0, 4'hf, 4'hf);
    for (int i = 0; i < 4; i++) rd_chk("R8", 2'd2, 1'b0, {16'(16'h0500 + i), 4'h0}, 1);
    rd_chk("R8", 2'd2, 1'b0, 20'h05000, 0);
    rd_chk("R8", 2'd2, 1'b0, 20'h05040, 1);
    rd_chk("R8", 2'd2, 1'b0, 20'h05004, 0);
    rd_chk("R8", 2'd2, 1'b0, 20'h05028, 0);
    rd_chk("R8", 2'd2, 1'b0, 20'h0503c, 0);
    rd_chk("R8", 2'd2, 1'b0, 20'h05040, 0);
    rd_chk("R8", 2'd2, 1'b0, 20'h05010, 1);

    // R7: allocation enables per access type
    set_cfg(4'd0, 2'd0, 4'h0, 4'hf, 4'h0);
    rd_chk("R7", 2'd0, 1'b0, 20'h06000, 1);
    rd_chk("R7", 2'd0, 1'b0, 20'h06000, 1);
    rd_chk("R7", 2'd0, 1'b1, 20'h06000, 1);
    rd_chk("R7", 2'd0, 1'b1, 20'h06000, 0);
    set_cfg(4'd0, 2'd0, 4'h0, 4'hf, 4'b0100);
    rd_chk("R7", 2'd0, 1'b0, 20'h06100, 1);
    rd_chk("R7", 2'd0, 1'b0, 20'h06200, 1);
    rd_chk("R7", 2'd0, 1'b0, 20'h06100, 1);
    rd_chk("R7", 2'd0, 1'b0, 20'h06104, 0);

    // R9: configuration change invalidates
    rd_chk("R9", 2'd3, 1'b1, 20'h06300, 1);
    rd_chk("R9", 2'd3, 1'b1, 20'h06300, 0);
    set_cfg(4'd0, 2'd0, 4'h0, 4'b1110, 4'b0100);
    rd_chk("R9", 2'd3, 1'b1, 20'h06300, 1);

    // R10: permission sweep
    for (int m = 0; m < 4; m++) begin
      for (int code = 0; code < 4; code++) begin
        for (int wr = 0; wr < 2; wr++) begin
          bit exp_err;
          cfg_perm = 8'hff;
          cfg_perm[2*m +: 2] = 2'(code);
          exp_err = wr ? (code[1] == 1'b0) : (code[0] == 1'b0);
          access(wr[0], 2'(m), 1'b0, 20'h07000, lat, d, e);
          chk("R10", "error", e, exp_err);
          if (exp_err || wr == 1) chk("R10", "immediate", lat, 0);
          else                    chk("R10", "read data", d, exp_word(20'h07000));
        end
      end
    end
    cfg_perm = 8'hff;

    // R11: permitted write leaves the buffer untouched
    rd_chk("R11", 2'd1, 1'b0, 20'h08004, 1);
    access(1'b1, 2'd1, 1'b0, 20'h08004, lat, d, e);
    chk("R11", "write error", e, 0);
    chk("R11", "write latency", lat, 0);
    rd_chk("R11", 2'd1, 1'b0, 20'h08004, 0);
    idle(2);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule